// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Sticky Enable

This block is a watchdog for a small controller. An external tick input feeds a
power-of-two prescaler, whose carry advances a wide main counter. When that main
counter wraps, the block sends out a reset pulse of fixed length and latches an
overflow flag. Software has to restart the count by writing a clear strobe
often enough to stop the wrap from happening.

All control goes through one 8-bit register. Software can set the enable bit but
cannot clear it, so once armed the watchdog runs until a power-on reset. An
idle-run bit decides whether counting carries on while the CPU reports idle. The
overflow flag stays set until software writes 0 to it. Clock generation and the
distribution of the reset are outside this block.

Top module: `oneshot_wdog`

## Requirements
- R1: After power-on reset (rst_ni low) the register reads 0x00 and wdt_rst_o is low.
- R2: The enable is bit 0. Writing 1 sets it. A later write with bit 0 at 0 does not clear it, and counting goes on.
- R3: Writing 1 to bit 1 (clear strobe) restarts the prescaler and the main counter from zero. Bit 1 always reads 0.
- R4: The prescale select sits in bits 5:3. With select value p, the main counter advances once every 2^(p+1) counted ticks. An overflow therefore comes 2^(p+1)·2^CNT_W counted ticks after a clear.
- R5: When idle_i is high and the idle-run bit (bit 2) is 0, counting is frozen. When bit 2 is 1, counting continues during idle.
- R6: An overflow drives wdt_rst_o high for exactly RST_LEN cycles, starting the cycle after the overflowing tick. Counting restarts from zero.
- R7: The overflow flag is bit 7. An overflow sets it. Only a register write with bit 7 at 0 clears it, and writing 1 leaves it unchanged. If an overflow and a flag-clearing write fall in the same cycle, the flag ends up set.
- R8: If a clear strobe and the tick that would overflow fall in the same cycle, the clear wins and no reset pulse is produced.
- R9: No counting happens while the watchdog is disabled or while tick_i is low.
- R10: A read returns {flag, 0, prescale[2:0], idle-run, 0, enable} from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Count-enable tick from the clock source |
| idle_i | input | 1 | CPU idle indication |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
Two pairs of functions can land in the same cycle. In the first, a clear strobe arrives on the tick that would wrap the counter. In the second, the overflow coincides with a software write that clears the flag. The bench produces both by issuing a clear and counting off one tick less than the period, then placing the write on the final tick. It judges the outcome from the reset output and from the flag as read back. The first case must give no pulse and then a full fresh period. The second must give a pulse with the flag still set. A behavioural model that counts ticks since the last clear also checks both outputs on every clock.

// File: rtl/oneshot_wdog_pkg.sv
package oneshot_wdog_pkg;
  localparam int REG_W    = 8;
  localparam int PS_W     = 3;
  localparam int BIT_EN   = 0;
  localparam int BIT_CLR  = 1;
  localparam int BIT_IDLE = 2;
  localparam int PS_LSB   = 3;
  localparam int BIT_FLAG = 7;

  typedef struct packed {
    logic            flag;
    logic            en;
    logic            idle_run;
    logic [PS_W-1:0] ps;
  } cfg_t;
endpackage

// File: rtl/oneshot_wdog_ctrl.sv
module oneshot_wdog_ctrl
  import oneshot_wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ovf_i,
  output cfg_t             cfg_o,
  output logic             clr_o
);
  cfg_t cfg_q;
  logic unused_wdata;

  assign unused_wdata = wdata_i[6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      // overflow beats a same-cycle flag clear
      if (ovf_i)                           cfg_q.flag <= 1'b1;
      else if (we_i && !wdata_i[BIT_FLAG]) cfg_q.flag <= 1'b0;
      if (we_i) begin
        cfg_q.en       <= cfg_q.en | wdata_i[BIT_EN];
        cfg_q.idle_run <= wdata_i[BIT_IDLE];
        cfg_q.ps       <= wdata_i[PS_LSB +: PS_W];
      end
    end
  end

  assign cfg_o = cfg_q;
  assign clr_o = we_i & wdata_i[BIT_CLR];
endmodule

// File: rtl/oneshot_wdog_presc.sv
module oneshot_wdog_presc #(
  parameter int PRE_W = 8,
  parameter int PS_W  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            carry_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // division 2^(ps+1): low ps+1 bits form the active window
  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign mask[g] = (g <= int'(ps_i));
  end

  assign carry_o = step_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (carry_o) pre_q <= '0;
    else if (step_i)  pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/oneshot_wdog_cnt.sv
module oneshot_wdog_cnt #(
  parameter int CNT_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = inc_i && !clr_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/oneshot_wdog_pulse.sv
module oneshot_wdog_pulse #(
  parameter int RST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int PW = $clog2(RST_LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           left_q <= '0;
    else if (fire_i)       left_q <= PW'(RST_LEN);
    else if (left_q != '0) left_q <= left_q - PW'(1);
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/oneshot_wdog.sv
module oneshot_wdog
  import oneshot_wdog_pkg::*;
#(
  parameter int PRE_W   = 8,
  parameter int CNT_W   = 15,
  parameter int RST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             idle_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             wdt_rst_o
);
  cfg_t cfg;
  logic clr, step, carry, ovf;

  oneshot_wdog_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .ovf_i   (ovf),
    .cfg_o   (cfg),
    .clr_o   (clr)
  );

  assign step = cfg.en && tick_i && (!idle_i || cfg.idle_run) && !clr;

  oneshot_wdog_presc #(.PRE_W(PRE_W), .PS_W(PS_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .step_i  (step),
    .ps_i    (cfg.ps),
    .carry_o (carry)
  );

  oneshot_wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (carry),
    .ovf_o  (ovf)
  );

  oneshot_wdog_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (ovf),
    .pulse_o (wdt_rst_o)
  );

  always_comb begin
    reg_rdata_o                     = '0;
    reg_rdata_o[BIT_FLAG]           = cfg.flag;
    reg_rdata_o[PS_LSB +: PS_W]     = cfg.ps;
    reg_rdata_o[BIT_IDLE]           = cfg.idle_run;
    reg_rdata_o[BIT_EN]             = cfg.en;
  end
endmodule

// File: rtl/oneshot_wdog_chk.sv
module oneshot_wdog_chk #(
  parameter int RST_LEN = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       wdt_rst_o
);
  int hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= 0;
    else if (wdt_rst_o) hi_cnt <= hi_cnt + 1;
    else                hi_cnt <= 0;
  end

  assert_en_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[0] |=> reg_rdata_o[0]);

  assert_pulse_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (hi_cnt < RST_LEN));

  assert_pulse_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst_o) |-> (hi_cnt == RST_LEN));

  assert_flag_on_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> reg_rdata_o[7]);

  assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[7] && !reg_we_i) |=> reg_rdata_o[7]);

  assert_clr_no_fire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[1]) |=> !$rose(wdt_rst_o));

  assert_off_no_rst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[0] |-> !wdt_rst_o);
endmodule

bind oneshot_wdog oneshot_wdog_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .wdt_rst_o   (wdt_rst_o)
);

// File: tb/oneshot_wdog_test.sv
module oneshot_wdog_test;
  localparam int CW = 4;
  localparam int RL = 4;

  logic       clk = 0, rst_n = 0, tick = 0, idle = 0, we = 0;
  logic [7:0] wdata = 0;
  wire  [7:0] rdata;
  wire        wrst;

  always #10 clk = ~clk;

  oneshot_wdog #(.CNT_W(CW), .RST_LEN(RL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .idle_i(idle),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wdt_rst_o(wrst)
  );

  int checks = 0, errors = 0;
  bit m_en, m_idle, m_flag;
  int m_ps, m_acc, m_rst;

  function automatic int period(int p);
    return (2 ** (p + 1)) * (2 ** CW);
  endfunction

  function automatic logic [7:0] cfg(int p, bit idl, bit clr, bit en, bit flag);
    logic [2:0] ps3 = p[2:0];
    return {flag, 1'b0, ps3, idl, clr, en};
  endfunction

  // reference model: ticks since last clear
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_idle = 0; m_flag = 0; m_ps = 0; m_acc = 0; m_rst = 0;
    end else begin
      bit act, ovf;
      act = m_en && tick && (!idle || m_idle);
      ovf = 0;
      if (we && wdata[1]) m_acc = 0;
      else if (act) begin
        m_acc++;
        if (m_acc == period(m_ps)) begin ovf = 1; m_acc = 0; end
      end
      if (ovf) m_rst = RL;
      else if (m_rst > 0) m_rst--;
      if (ovf) m_flag = 1;
      else if (we && !wdata[7]) m_flag = 0;
      if (we) begin
        m_en   = m_en | wdata[0];
        m_idle = wdata[2];
        m_ps   = int'(wdata[5:3]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] exp_r;
      exp_r = {m_flag, 1'b0, m_ps[2:0], m_idle, 1'b0, m_en};
      checks++;
      if (rdata !== exp_r || wrst !== (m_rst > 0)) begin
        errors++;
        $display("FAIL model R4/R6/R7: rdata=%h rst=%0b expected rdata=%h rst=%0b",
                 rdata, wrst, exp_r, (m_rst > 0));
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); we = 1; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!wrst && n < 10000) begin @(negedge clk); n++; end
  endtask

  task automatic pulse(output int m);
    m = 0;
    while (wrst && m < 100) begin @(negedge clk); m++; end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int n, m;
    repeat (3) @(negedge clk);
    chk(rdata == 8'h00, "R1 reset reg", rdata, 0);
    chk(wrst == 0, "R1 reset out", wrst, 0);
    rst_n = 1;
    tick = 1;
    repeat (100) @(negedge clk);
    chk(wrst == 0, "R9 disabled no rst", wrst, 0);

    for (int p = 0; p < 8; p++) begin
      wr(cfg(p, 0, 1, 1, 0));
      measure(n);
      chk(n == period(p), "R4 period", n, period(p));
      chk(rdata[7] == 1, "R7 flag set", rdata[7], 1);
      pulse(m);
      chk(m == RL, "R6 pulse length", m, RL);
    end

    wr(cfg(0, 0, 1, 1, 0));
    measure(n); pulse(m);
    wr(cfg(0, 0, 0, 1, 1));
    chk(rdata[7] == 1, "R7 write 1 keeps flag", rdata[7], 1);
    wr(cfg(0, 0, 0, 1, 0));
    chk(rdata[7] == 0, "R7 write 0 clears flag", rdata[7], 0);

    wr(cfg(0, 0, 1, 0, 0));
    chk(rdata[0] == 1, "R2 enable sticky", rdata[0], 1);
    measure(n);
    chk(n == period(0), "R2 still counting", n, period(0));
    pulse(m);

    wr(cfg(0, 0, 1, 1, 0));
    chk(rdata[1] == 0, "R3 clear reads 0", rdata[1], 0);
    chk(rdata == 8'h01, "R10 layout", rdata, 1);
    repeat (20) @(negedge clk);
    wr(cfg(0, 0, 1, 1, 0));
    measure(n);
    chk(n == period(0), "R3 restart from zero", n, period(0));
    pulse(m);

    wr(cfg(0, 0, 1, 1, 1));
    repeat (30) @(negedge clk);
    wr(cfg(0, 0, 1, 1, 1));
    measure(n);
    chk(n == period(0), "R8 clear beats overflow", n, period(0));
    pulse(m);

    wr(cfg(0, 0, 1, 1, 1));
    repeat (30) @(negedge clk);
    wr(cfg(0, 0, 0, 1, 0));
    chk(wrst == 1, "R7 coincident overflow", wrst, 1);
    chk(rdata[7] == 1, "R7 overflow beats clear", rdata[7], 1);
    pulse(m);

    wr(cfg(0, 0, 1, 1, 1));
    idle = 1;
    repeat (100) @(negedge clk);
    chk(wrst == 0, "R5 idle freeze", wrst, 0);
    idle = 0;
    measure(n);
    chk(n == period(0), "R5 resume after idle", n, period(0));
    pulse(m);
    wr(cfg(0, 1, 1, 1, 1));
    idle = 1;
    measure(n);
    chk(n == period(0), "R5 idle-run counts", n, period(0));
    idle = 0;
    pulse(m);

    wr(cfg(0, 0, 1, 1, 1));
    tick = 0;
    repeat (50) @(negedge clk);
    chk(wrst == 0, "R9 no tick no count", wrst, 0);
    tick = 1;
    measure(n);
    chk(n == period(0), "R9 count resumes", n, period(0));
    pulse(m);

    wr(cfg(5, 1, 1, 1, 0));
    chk(rdata == 8'h2D, "R10 readback", rdata, 8'h2D);

    finish_run();
  end
endmodule